// File: doc/BRIEF.md
# Surge Pulse Classifier with Latched Severity

This block sits behind the analog comparators of one surge-sensing channel and decides whether a threshold-crossing pulse is a real surge or a benign transient. Three comparator levels come in: a warning level, a severe-stress level and a level that indicates probable surge-protector conduction. Each level passes through a programmable digital deglitch filter. The block then measures the rise time and the over-threshold duration of the pulse. It rejects pulses whose edge is too slow, whose length falls outside a programmed window, or that overlap reported breaker or startup activity.

A pulse that qualifies sets a sticky event flag and stores the highest severity reached, together with its rise and duration counts. The flag stays set until the controller acknowledges it. Qualified surges that arrive while the flag is still set are counted as overruns, and they can only raise the stored severity. A per-channel event counter supports repetition analysis. A one-cycle interrupt pulse marks every qualified surge.

Top module: `surge_classifier`

## Requirements
- R1: A comparator level change is used only after the raw input has differed from the filtered value for deglitch_len_i+1 consecutive clock samples. Shorter excursions are ignored.
- R2: After a qualified surge, event_o stays at 1 through any number of cycles until ack_i is sampled high. ack_i then clears event_o and returns severity_o to 0 on the next cycle.
- R3: severity_o holds the highest level reached while the filtered warning level was high, encoded 0 = none, 1 = warning, 2 = severe, 3 = protector action.
- R4: rise_o is the number of cycles from the filtered warning rise to the filtered severe rise. rise_na_o is 1 when the severe level was never reached during the pulse.
- R5: dur_o is the number of cycles the filtered warning level was high. A pulse qualifies only if dur_min_i <= dur_o <= dur_max_i.
- R6: A pulse that reaches the severe level with a rise count greater than rise_max_i is treated as inrush and does not qualify.
- R7: A pulse during any cycle of which switching_i was high is treated as benign switching and does not qualify.
- R8: Each qualified surge raises event_count_o by one (saturating) and pulses irq_o high for exactly one cycle.
- R9: A qualified surge that arrives while event_o is set and ack_i is low increments overrun_count_o. It raises severity_o if its level is higher and leaves rise_o, rise_na_o and dur_o unchanged.
- R10: After reset, event_o, severity_o, irq_o, event_count_o and overrun_count_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| deglitch_len_i | input | DGL_W | Deglitch length N; a change must persist N+1 samples |
| cmp_warn_i | input | 1 | Raw warning-level comparator output |
| cmp_sev_i | input | 1 | Raw severe-level comparator output |
| cmp_spd_i | input | 1 | Raw protector-action comparator output |
| switching_i | input | 1 | Breaker closing or startup activity in progress |
| ack_i | input | 1 | Acknowledge strobe from the controller |
| rise_max_i | input | CNT_W | Largest rise count still counted as a fast edge |
| dur_min_i | input | CNT_W | Shortest qualifying duration |
| dur_max_i | input | CNT_W | Longest qualifying duration |
| event_o | output | 1 | Latched surge flag |
| severity_o | output | 2 | Stored severity code |
| rise_o | output | CNT_W | Captured rise count |
| rise_na_o | output | 1 | Rise not applicable (severe level not reached) |
| dur_o | output | CNT_W | Captured duration count |
| irq_o | output | 1 | One-cycle pulse per qualified surge |
| event_count_o | output | EVT_W | Qualified surge count |
| overrun_count_o | output | OVR_W | Surges that arrived while the flag was set |

## Verification
A wrong pulse tracker shows up in dur_o or rise_o one cycle after the filtered warning level falls. The filter delay N is added on top of that, so a fault is visible about N+2 cycles after the raw pulse ends. A wrong qualifier shows in event_o, irq_o and event_count_o within the same latency, because each of them moves on every decision. A faulty latch is visible as a flag that drops without an acknowledge, or as a severity that falls while the flag is held. Both appear on the very next cycle. Overrun handling is exposed by the overrun count, which can be compared against the rise and duration fields that must stay frozen.

// File: rtl/surge_cls_pkg.sv
package surge_cls_pkg;

  typedef enum logic [1:0] {
    SEV_NONE   = 2'd0,
    SEV_WARN   = 2'd1,
    SEV_SEVERE = 2'd2,
    SEV_SPD    = 2'd3
  } sev_e;

  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned LVL_WARN = 0;
  localparam int unsigned LVL_SEV  = 1;
  localparam int unsigned LVL_SPD  = 2;

  // Map filtered comparator levels to a severity code (highest wins).
  function automatic sev_e level_of(input logic warn, input logic sev, input logic spd);
    if (spd)       return SEV_SPD;
    else if (sev)  return SEV_SEVERE;
    else if (warn) return SEV_WARN;
    else           return SEV_NONE;
  endfunction

  function automatic sev_e sev_hi(input sev_e a, input sev_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/surge_deglitch.sv
module surge_deglitch #(
  parameter int unsigned DGL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DGL_W-1:0] len_i,
  input  logic             raw_i,
  output logic             flt_o
);

  logic [DGL_W-1:0] run_q;
  logic             flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      run_q <= '0;
    end else if (raw_i == flt_q) begin
      run_q <= '0;
    end else if (run_q >= len_i) begin
      flt_q <= raw_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign flt_o = flt_q;

endmodule

// File: rtl/surge_pulse_tracker.sv
module surge_pulse_tracker
  import surge_cls_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warn_i,
  input  logic             sev_i,
  input  logic             spd_i,
  input  logic             switching_i,
  output logic             end_o,
  output logic [CNT_W-1:0] dur_o,
  output logic [CNT_W-1:0] rise_o,
  output logic             sev_seen_o,
  output sev_e             peak_o,
  output logic             sw_seen_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic             act_q;
  logic [CNT_W-1:0] dur_q, rise_q;
  logic             seen_q, sw_q;
  sev_e             peak_q;
  sev_e             lvl_now;

  assign lvl_now = level_of(warn_i, sev_i, spd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      dur_q  <= '0;
      rise_q <= '0;
      seen_q <= 1'b0;
      sw_q   <= 1'b0;
      peak_q <= SEV_NONE;
    end else begin
      act_q <= warn_i;
      if (warn_i) begin
        if (!act_q) begin
          dur_q  <= CNT_W'(1);
          rise_q <= '0;
          seen_q <= sev_i;
          sw_q   <= switching_i;
          peak_q <= lvl_now;
        end else begin
          dur_q  <= sat_inc(dur_q);
          if (!seen_q) begin
            rise_q <= sat_inc(rise_q);
            seen_q <= sev_i;
          end
          sw_q   <= sw_q | switching_i;
          peak_q <= sev_hi(peak_q, lvl_now);
        end
      end
    end
  end

  assign end_o      = act_q & ~warn_i;
  assign dur_o      = dur_q;
  assign rise_o     = rise_q;
  assign sev_seen_o = seen_q;
  assign peak_o     = peak_q;
  assign sw_seen_o  = sw_q;

endmodule

// File: rtl/surge_event_latch.sv
module surge_event_latch
  import surge_cls_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned EVT_W = 16,
  parameter int unsigned OVR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qual_i,
  input  logic             ack_i,
  input  sev_e             peak_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic             rise_na_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             flag_o,
  output sev_e             sev_o,
  output logic [CNT_W-1:0] rise_o,
  output logic             rise_na_o,
  output logic [CNT_W-1:0] dur_o,
  output logic             irq_o,
  output logic [EVT_W-1:0] evt_cnt_o,
  output logic [OVR_W-1:0] ovr_cnt_o
);

  localparam logic [EVT_W-1:0] EVT_MAX = {EVT_W{1'b1}};
  localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

  function automatic logic [EVT_W-1:0] evt_inc(input logic [EVT_W-1:0] v);
    return (v == EVT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [OVR_W-1:0] ovr_inc(input logic [OVR_W-1:0] v);
    return (v == OVR_MAX) ? v : v + 1'b1;
  endfunction

  logic fresh, stacked;
  assign fresh   = qual_i & (~flag_o | ack_i);
  assign stacked = qual_i & flag_o & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o    <= 1'b0;
      sev_o     <= SEV_NONE;
      rise_o    <= '0;
      rise_na_o <= 1'b0;
      dur_o     <= '0;
      irq_o     <= 1'b0;
      evt_cnt_o <= '0;
      ovr_cnt_o <= '0;
    end else begin
      irq_o <= qual_i;
      if (qual_i) evt_cnt_o <= evt_inc(evt_cnt_o);
      if (fresh) begin
        flag_o    <= 1'b1;
        sev_o     <= peak_i;
        rise_o    <= rise_i;
        rise_na_o <= rise_na_i;
        dur_o     <= dur_i;
      end else if (stacked) begin
        sev_o     <= sev_hi(sev_o, peak_i);
        ovr_cnt_o <= ovr_inc(ovr_cnt_o);
      end else if (ack_i) begin
        flag_o <= 1'b0;
        sev_o  <= SEV_NONE;
      end
    end
  end

endmodule

// File: rtl/surge_classifier.sv
module surge_classifier
  import surge_cls_pkg::*;
#(
  parameter int unsigned DGL_W = 4,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned EVT_W = 16,
  parameter int unsigned OVR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DGL_W-1:0] deglitch_len_i,
  input  logic             cmp_warn_i,
  input  logic             cmp_sev_i,
  input  logic             cmp_spd_i,
  input  logic             switching_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] rise_max_i,
  input  logic [CNT_W-1:0] dur_min_i,
  input  logic [CNT_W-1:0] dur_max_i,
  output logic             event_o,
  output logic [1:0]       severity_o,
  output logic [CNT_W-1:0] rise_o,
  output logic             rise_na_o,
  output logic [CNT_W-1:0] dur_o,
  output logic             irq_o,
  output logic [EVT_W-1:0] event_count_o,
  output logic [OVR_W-1:0] overrun_count_o
);

  logic [NUM_LVL-1:0] raw_lvl, flt_lvl;
  assign raw_lvl[LVL_WARN] = cmp_warn_i;
  assign raw_lvl[LVL_SEV]  = cmp_sev_i;
  assign raw_lvl[LVL_SPD]  = cmp_spd_i;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_dgl
    surge_deglitch #(.DGL_W(DGL_W)) u_dgl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .len_i (deglitch_len_i),
      .raw_i (raw_lvl[g]),
      .flt_o (flt_lvl[g])
    );
  end

  // Named internal events, brought out for the checker.
  logic             pulse_end;
  logic [CNT_W-1:0] meas_dur, meas_rise;
  logic             sev_seen, sw_seen;
  sev_e             peak_lvl;
  logic             dur_ok, rise_ok, qual_evt;
  sev_e             sev_q;

  surge_pulse_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warn_i     (flt_lvl[LVL_WARN]),
    .sev_i      (flt_lvl[LVL_SEV]),
    .spd_i      (flt_lvl[LVL_SPD]),
    .switching_i(switching_i),
    .end_o      (pulse_end),
    .dur_o      (meas_dur),
    .rise_o     (meas_rise),
    .sev_seen_o (sev_seen),
    .peak_o     (peak_lvl),
    .sw_seen_o  (sw_seen)
  );

  assign dur_ok   = (meas_dur >= dur_min_i) && (meas_dur <= dur_max_i);
  assign rise_ok  = ~sev_seen | (meas_rise <= rise_max_i);
  assign qual_evt = pulse_end & dur_ok & rise_ok & ~sw_seen;

  surge_event_latch #(.CNT_W(CNT_W), .EVT_W(EVT_W), .OVR_W(OVR_W)) u_lat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qual_i   (qual_evt),
    .ack_i    (ack_i),
    .peak_i   (peak_lvl),
    .rise_i   (meas_rise),
    .rise_na_i(~sev_seen),
    .dur_i    (meas_dur),
    .flag_o   (event_o),
    .sev_o    (sev_q),
    .rise_o   (rise_o),
    .rise_na_o(rise_na_o),
    .dur_o    (dur_o),
    .irq_o    (irq_o),
    .evt_cnt_o(event_count_o),
    .ovr_cnt_o(overrun_count_o)
  );

  assign severity_o = sev_q;

endmodule

// File: rtl/surge_classifier_chk.sv
module surge_classifier_chk #(
  parameter int unsigned EVT_W = 16,
  parameter int unsigned OVR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             qual_evt,
  input logic             event_o,
  input logic [1:0]       severity_o,
  input logic             irq_o,
  input logic [EVT_W-1:0] event_count_o,
  input logic [OVR_W-1:0] overrun_count_o
);

  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o && !ack_i |=> event_o); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !qual_evt |=> !event_o && severity_o == 2'd0); // R2

  AST_SEV_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> severity_o != 2'd0); // R3

  AST_IRQ_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(event_o) |-> irq_o); // R8

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_count_o != $past(event_count_o) |->
      event_count_o == EVT_W'($past(event_count_o) + 1'b1) && irq_o); // R8

  AST_OVR_ONLY_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_count_o != $past(overrun_count_o) |->
      $past(event_o) && !$past(ack_i) && $past(qual_evt)); // R9

  AST_SEV_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o && $past(event_o) && !$past(ack_i) |-> severity_o >= $past(severity_o)); // R9

endmodule

bind surge_classifier surge_classifier_chk #(.EVT_W(EVT_W), .OVR_W(OVR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ack_i          (ack_i),
  .qual_evt       (qual_evt),
  .event_o        (event_o),
  .severity_o     (severity_o),
  .irq_o          (irq_o),
  .event_count_o  (event_count_o),
  .overrun_count_o(overrun_count_o)
);

// File: tb/surge_classifier_tb.sv
`timescale 1ns/1ps
module surge_classifier_tb;

  localparam int DGL_W = 4;
  localparam int CNT_W = 12;
  localparam int EVT_W = 16;
  localparam int OVR_W = 8;
  localparam int NDG   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DGL_W-1:0] dgl_len = DGL_W'(NDG);
  logic             warn = 0, sev = 0, spd = 0, sw = 0, ack = 0;
  logic [CNT_W-1:0] rise_max = 5, dmin = 4, dmax = 20;
  logic             event_o, rise_na_o, irq_o;
  logic [1:0]       severity_o;
  logic [CNT_W-1:0] rise_o, dur_o;
  logic [EVT_W-1:0] evt_cnt;
  logic [OVR_W-1:0] ovr_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_seen = 0;
  int exp_evt = 0;

  always #2.5 clk = ~clk;

  surge_classifier #(.DGL_W(DGL_W), .CNT_W(CNT_W), .EVT_W(EVT_W), .OVR_W(OVR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .deglitch_len_i(dgl_len),
    .cmp_warn_i(warn), .cmp_sev_i(sev), .cmp_spd_i(spd),
    .switching_i(sw), .ack_i(ack),
    .rise_max_i(rise_max), .dur_min_i(dmin), .dur_max_i(dmax),
    .event_o(event_o), .severity_o(severity_o), .rise_o(rise_o),
    .rise_na_o(rise_na_o), .dur_o(dur_o), .irq_o(irq_o),
    .event_count_o(evt_cnt), .overrun_count_o(ovr_cnt)
  );

  always @(negedge clk) if (rst_n && irq_o) irq_seen++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Raw pulse of h samples; severe from sample sd on, protector level from pd on.
  task automatic pulse(input int h, input int sd, input int pd, input bit swon);
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      warn = 1'b1;
      sev  = (i >= sd);
      spd  = (i >= pd);
      sw   = swon;
    end
    @(negedge clk);
    warn = 0; sev = 0; spd = 0; sw = 0;
    repeat (NDG + 6) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "event", event_o, 0);
    chk("R10", "severity", severity_o, 0);
    chk("R10", "irq", irq_o, 0);
    chk("R10", "event count", evt_cnt, 0);
    chk("R10", "overrun", ovr_cnt, 0);
  endtask

  task automatic t_warn_only();
    pulse(8, 99, 99, 0); exp_evt++;
    chk("R5", "event", event_o, 1);
    chk("R3", "severity", severity_o, 1);
    chk("R4", "rise_na", rise_na_o, 1);
    chk("R5", "duration", dur_o, 8);
    chk("R8", "event count", evt_cnt, exp_evt);
    repeat (10) @(negedge clk);
    chk("R2", "event held", event_o, 1);
  endtask

  task automatic t_ack();
    do_ack();
    chk("R2", "event after ack", event_o, 0);
    chk("R2", "severity after ack", severity_o, 0);
  endtask

  task automatic t_severe_rise();
    pulse(10, 3, 99, 0); exp_evt++;
    chk("R3", "severity", severity_o, 2);
    chk("R4", "rise", rise_o, 3);
    chk("R4", "rise_na", rise_na_o, 0);
    chk("R5", "duration", dur_o, 10);
    do_ack();
  endtask

  task automatic t_slow_rise();
    pulse(12, 7, 99, 0);
    chk("R6", "event on slow edge", event_o, 0);
    chk("R6", "count on slow edge", evt_cnt, exp_evt);
  endtask

  task automatic t_window();
    pulse(30, 99, 99, 0);
    chk("R5", "event on long pulse", event_o, 0);
    pulse(3, 99, 99, 0);
    chk("R5", "event on short pulse", event_o, 0);
    chk("R5", "count after window rejects", evt_cnt, exp_evt);
  endtask

  task automatic t_switching();
    pulse(8, 2, 99, 1);
    chk("R7", "event during switching", event_o, 0);
    chk("R7", "count during switching", evt_cnt, exp_evt);
  endtask

  task automatic t_deglitch();
    dmin = 1;
    pulse(2, 99, 99, 0);
    chk("R1", "event on glitch", event_o, 0);
    chk("R1", "count on glitch", evt_cnt, exp_evt);
    pulse(3, 99, 99, 0); exp_evt++;
    chk("R1", "event on held level", event_o, 1);
    chk("R1", "duration on held level", dur_o, 3);
    do_ack();
    dmin = 4;
  endtask

  task automatic t_spd_and_overrun();
    pulse(10, 1, 2, 0); exp_evt++;
    chk("R3", "protector severity", severity_o, 3);
    chk("R4", "rise", rise_o, 1);
    pulse(6, 99, 99, 0); exp_evt++;
    chk("R9", "overrun", ovr_cnt, 1);
    chk("R9", "severity kept", severity_o, 3);
    chk("R9", "rise kept", rise_o, 1);
    chk("R9", "duration kept", dur_o, 10);
    chk("R8", "event count", evt_cnt, exp_evt);
    do_ack();
  endtask

  task automatic t_overrun_raise();
    pulse(8, 0, 99, 0); exp_evt++;
    chk("R3", "severity", severity_o, 2);
    chk("R4", "rise zero", rise_o, 0);
    pulse(9, 0, 4, 0); exp_evt++;
    chk("R9", "overrun", ovr_cnt, 2);
    chk("R9", "severity raised", severity_o, 3);
    chk("R9", "duration kept", dur_o, 8);
    do_ack();
    chk("R8", "irq pulses", irq_seen, exp_evt);
    chk("R8", "event count", evt_cnt, exp_evt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_warn_only();
    t_ack();
    t_severe_rise();
    t_slow_rise();
    t_window();
    t_switching();
    t_deglitch();
    t_spd_and_overrun();
    t_overrun_raise();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule